// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns pin activity on a general-purpose I/O port into interrupt requests. It watches the already-synchronized level of every pin and compares it with the level it held one clock earlier. A low-to-high change is reported when that pin's rising enable is on, and a high-to-low change when its falling enable is on. Reported changes are held in a status register that software clears by writing ones.

The rising and falling enables of each pin are never written as a whole word. Software writes a mask to a set address to turn pins on, or to a clear address to turn them off, so one routine can change one pin without a read-modify-write. The status bits are gathered into groups of sixteen pins. Each group drives one level interrupt output, gated by a bit in a group-enable register. The output stays high until every status bit of that group has been cleared. The block does not know the pin direction, so pins that the chip itself drives are watched in the same way.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset, the rising enables, the falling enables, the status bits and the group enables all read as zero, and every interrupt output is low.
- R2: A write to address 0x14 sets the rising enables of the pins whose data bits are 1, and a write to 0x18 clears them. Addresses 0x20 and 0x24 do the same for the falling enables. Bits written as 0 keep their value. The rising enables read back at 0x10 and the falling enables at 0x1C.
- R3: A pin whose sampled level goes from 0 to 1 between two clock edges sets its status bit (read at 0x28) on the second edge only if its rising enable is set. A change from 1 to 0 sets the bit only if its falling enable is set.
- R4: With both enables set, every transition of a pin sets its status bit. A pin held at a steady level adds no new event.
- R5: Writing to 0x28 clears each status bit whose data bit is 1 and leaves bits written as 0 unchanged.
- R6: If a reported edge and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R7: The register at 0x08 holds one enable bit per group (bit g for group g). Output irq_o[g] is high exactly when enable bit g is set and at least one status bit in positions 16g to 16g+15 is set. Group 0 covers status bits 15:0 and group 1 covers bits 31:16.
- R8: irq_o[g] is a level. It stays high while any status bit of group g remains set, and it falls only once the last of them has been cleared.
- R9: Address 0x2C returns the current sampled pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for bus_addr, combinational |
| irq_o | output | NUM_GROUPS | Level interrupt, one per 16-pin group |

## Verification
The hardest case to reach is a pin edge and a clearing write that land on the same status bit on the same clock edge. The bench first sets two status bits through both-edge enables. Then, on one falling clock edge, it toggles only one of the two pins and writes ones to both status bits. The toggled bit must survive and the other must clear. The group-level case needs two pending bits in one group, which are then cleared one at a time while the output is watched.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;
    localparam int OFF_GRP_EN   = 'h08;
    localparam int OFF_RISE_RD  = 'h10;
    localparam int OFF_RISE_SET = 'h14;
    localparam int OFF_RISE_CLR = 'h18;
    localparam int OFF_FALL_RD  = 'h1C;
    localparam int OFF_FALL_SET = 'h20;
    localparam int OFF_FALL_CLR = 'h24;
    localparam int OFF_STATUS   = 'h28;
    localparam int OFF_LEVEL    = 'h2C;
endpackage

// File: rtl/gpio_eirq_setclr_reg.sv
module gpio_eirq_setclr_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] val_o
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.val = (state_q.val | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign val_o = state_q.val;
endmodule

// File: rtl/gpio_eirq_capture.sv
module gpio_eirq_capture #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] status_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] status;
    } state_t;

    state_t              state_d, state_q;
    logic [NUM_PINS-1:0] rise_hit, fall_hit;

    always_comb begin
        rise_hit       = pin_i & ~state_q.prev & rise_en_i;
        fall_hit       = ~pin_i & state_q.prev & fall_en_i;
        state_d.prev   = pin_i;
        // new events are ORed after the clear, so an edge beats a clear
        state_d.status = (state_q.status & ~clr_i) | rise_hit | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status_o = state_q.status;
endmodule

// File: rtl/gpio_eirq_group_merge.sv
module gpio_eirq_group_merge #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 16,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input  logic [NUM_PINS-1:0]   status_i,
    input  logic [NUM_GROUPS-1:0] grp_en_i,
    output logic [NUM_GROUPS-1:0] irq_o
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign irq_o[g] = grp_en_i[g] & (|status_i[g*GROUP_W +: GROUP_W]);
    end
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 16,
    parameter int ADDR_W   = 8,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic [NUM_GROUPS-1:0] irq_o
);
    import gpio_eirq_pkg::*;

    typedef struct packed {
        logic [NUM_GROUPS-1:0] grp_en;
    } state_t;

    state_t              state_d, state_q;
    logic [NUM_PINS-1:0] rise_set, rise_clr, fall_set, fall_clr, stat_clr;
    logic [NUM_PINS-1:0] rise_en, fall_en, status;

    function automatic logic [NUM_PINS-1:0] strobe(input logic [ADDR_W-1:0] a, input int off);
        return (bus_we && a == ADDR_W'(off)) ? bus_wdata : '0;
    endfunction

    always_comb begin
        rise_set = strobe(bus_addr, OFF_RISE_SET);
        rise_clr = strobe(bus_addr, OFF_RISE_CLR);
        fall_set = strobe(bus_addr, OFF_FALL_SET);
        fall_clr = strobe(bus_addr, OFF_FALL_CLR);
        stat_clr = strobe(bus_addr, OFF_STATUS);
        state_d  = state_q;
        if (bus_we && bus_addr == ADDR_W'(OFF_GRP_EN))
            state_d.grp_en = bus_wdata[NUM_GROUPS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    gpio_eirq_setclr_reg #(.WIDTH(NUM_PINS)) i_rise_en (
        .clk(clk), .rst_n(rst_n), .set_i(rise_set), .clr_i(rise_clr), .val_o(rise_en));

    gpio_eirq_setclr_reg #(.WIDTH(NUM_PINS)) i_fall_en (
        .clk(clk), .rst_n(rst_n), .set_i(fall_set), .clr_i(fall_clr), .val_o(fall_en));

    gpio_eirq_capture #(.NUM_PINS(NUM_PINS)) i_capture (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_en_i(rise_en),
        .fall_en_i(fall_en), .clr_i(stat_clr), .status_o(status));

    gpio_eirq_group_merge #(.NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W)) i_merge (
        .status_i(status), .grp_en_i(state_q.grp_en), .irq_o(irq_o));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_GRP_EN))       bus_rdata = NUM_PINS'(state_q.grp_en);
        else if (bus_addr == ADDR_W'(OFF_RISE_RD)) bus_rdata = rise_en;
        else if (bus_addr == ADDR_W'(OFF_FALL_RD)) bus_rdata = fall_en;
        else if (bus_addr == ADDR_W'(OFF_STATUS))  bus_rdata = status;
        else if (bus_addr == ADDR_W'(OFF_LEVEL))   bus_rdata = pin_i;
    end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 16,
    parameter int ADDR_W   = 8,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_i,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [NUM_PINS-1:0]   bus_wdata,
    input logic [NUM_GROUPS-1:0] irq_o,
    input logic [NUM_PINS-1:0]   rise_en,
    input logic [NUM_PINS-1:0]   fall_en,
    input logic [NUM_PINS-1:0]   status
);
    logic [NUM_PINS-1:0] clr_seen;
    logic [1:0]          armed_q;

    assign clr_seen = (bus_we && bus_addr == ADDR_W'(gpio_eirq_pkg::OFF_STATUS)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         armed_q <= '0;
        else if (!armed_q[1]) armed_q <= armed_q + 2'd1;
    end

    // R2
    enables_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(rise_en) && $stable(fall_en)));

    // R5
    clear_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~status) & ~$past(clr_seen)) == '0));

    // R3
    event_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q[1] |=> (((status & ~$past(status)) & ~($past(pin_i) ^ $past(pin_i, 2))) == '0));

    // R7
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> (status != '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lvl
        // R8
        irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[g] && !bus_we) |=> irq_o[g]);
    end
endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(
    .NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .rise_en(rise_en), .fall_en(fall_en),
    .status(status)
);

// File: tb/test_gpio_edge_irq_ctrl.sv
module test_gpio_edge_irq_ctrl;
    localparam int N = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic [1:0]    irq;
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    gpio_edge_irq_ctrl #(.NUM_PINS(N), .GROUP_W(16), .ADDR_W(AW)) i_gpio_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [N-1:0] d);
        addr = AW'(a); #1; d = rdata;
    endtask

    task automatic drive(input logic [N-1:0] v);
        @(negedge clk); pins = v;
        @(negedge clk);
    endtask

    task automatic clean();
        wr('h18, '1); wr('h24, '1); wr('h28, '1); wr('h08, '0);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rd('h10, v); chk("R1 rise", v, '0);
        rd('h1C, v); chk("R1 fall", v, '0);
        rd('h28, v); chk("R1 status", v, '0);
        rd('h08, v); chk("R1 group", v, '0);
        chk("R1 irq", N'(irq), '0);
    endtask

    task automatic t_enables();
        logic [N-1:0] v;
        wr('h14, 32'h0000_00F0); rd('h10, v); chk("R2 set rise", v, 32'h0000_00F0);
        wr('h14, 32'h0000_0F00); rd('h10, v); chk("R2 set keeps", v, 32'h0000_0FF0);
        wr('h18, 32'h0000_0030); rd('h10, v); chk("R2 clr rise", v, 32'h0000_0FC0);
        wr('h20, 32'h0000_0005); rd('h1C, v); chk("R2 set fall", v, 32'h0000_0005);
        wr('h24, '1);            rd('h1C, v); chk("R2 clr fall", v, '0);
        rd('h10, v); chk("R2 rise untouched", v, 32'h0000_0FC0);
        clean();
    endtask

    task automatic t_rise_fall();
        logic [N-1:0] v;
        wr('h14, 32'h1); wr('h20, 32'h2);
        drive(pins | 32'h3); rd('h28, v); chk("R3 rise only bit0", v, 32'h1);
        wr('h28, '1);
        drive(pins & ~32'h3); rd('h28, v); chk("R3 fall only bit1", v, 32'h2);
        clean();
    endtask

    task automatic t_both();
        logic [N-1:0] v;
        wr('h14, 32'h4); wr('h20, 32'h4);
        drive(pins | 32'h4); rd('h28, v); chk("R4 up", v, 32'h4);
        wr('h28, 32'h4);
        repeat (3) @(negedge clk);
        rd('h28, v); chk("R4 steady no event", v, '0);
        drive(pins & ~32'h4); rd('h28, v); chk("R4 down", v, 32'h4);
        clean();
    endtask

    task automatic t_w1c();
        logic [N-1:0] v;
        wr('h14, 32'h300); wr('h20, 32'h300);
        drive(pins ^ 32'h300); rd('h28, v); chk("R5 setup", v, 32'h300);
        wr('h28, 32'h100); rd('h28, v); chk("R5 clear one", v, 32'h200);
        wr('h28, 32'h0);   rd('h28, v); chk("R5 zero write", v, 32'h200);
        wr('h28, 32'h200); rd('h28, v); chk("R5 clear last", v, '0);
        // R6: edge on bit 8 and clear of bits 8,9 on the same edge
        drive(pins ^ 32'h300); rd('h28, v); chk("R6 setup", v, 32'h300);
        @(negedge clk); pins = pins ^ 32'h100; we = 1'b1; addr = 'h28; wdata = 32'h300;
        @(negedge clk); we = 1'b0; wdata = '0;
        rd('h28, v); chk("R6 edge wins", v, 32'h100);
        clean();
    endtask

    task automatic t_groups();
        logic [N-1:0] v;
        wr('h14, 32'h0010_0008);
        drive(pins | 32'h0010_0008);
        rd('h28, v); chk("R7 status", v & 32'h0010_0008, 32'h0010_0008);
        chk("R7 gated off", N'(irq), '0);
        wr('h08, 32'h1); chk("R7 group0 only", N'(irq), 32'h1);
        wr('h08, 32'h3); chk("R7 both groups", N'(irq), 32'h3);
        rd('h08, v); chk("R7 group read", v, 32'h3);
        wr('h28, 32'h8); chk("R7 group0 drops", N'(irq), 32'h2);
        wr('h28, '1);    chk("R7 all clear", N'(irq), '0);
        clean();
    endtask

    task automatic t_level();
        logic [N-1:0] v;
        wr('h14, 32'h30); wr('h08, 32'h1);
        drive(pins | 32'h30);
        chk("R8 raised", N'(irq[0]), 32'h1);
        repeat (4) @(negedge clk);
        chk("R8 held", N'(irq[0]), 32'h1);
        wr('h28, 32'h10); chk("R8 one left", N'(irq[0]), 32'h1);
        wr('h28, 32'h20); chk("R8 last cleared", N'(irq[0]), '0);
        drive(32'hA5A5_0F0F);
        rd('h2C, v); chk("R9 level", v, 32'hA5A5_0F0F);
        clean();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_rise_fall();
        t_both();
        t_w1c();
        t_groups();
        t_level();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule